// File: doc/BRIEF.md
# Programmable Bit-Serial Polynomial Divider

This block performs modulo-2 long division of a serial message by a generator polynomial that is supplied at run time. It accepts one dividend bit per clock, most significant bit first, and keeps an N-bit remainder register. Subtraction is bitwise XOR with no carry or borrow. Each step's subtrahend is the generator's low N coefficients ANDed with the quotient bit, so the generator is a port rather than a fixed tap pattern.

In generator mode the host starts a run, streams the message and then raises the pad request. The block appends N zero bits by itself and raises done; the remainder is then the check value. In checker mode the host streams a received message followed by its check value and does not pad. A zero remainder means no error was detected.

The control is a four-state machine. IDLE is the state after reset. A start pulse from any state goes to SHIFT (the transition is called CLEAR). In SHIFT a pad request goes to PAD (ENTER_PAD). PAD goes to DONE after the last pad bit (PAD_END). DONE holds until the next start. With no start, pad request or valid bit, SHIFT stays in SHIFT (HOLD). With a valid bit it also stays, and takes one division step (STEP).

Top module: `polydiv_serial`

## Requirements
- R1: After reset, rem_o, quo_o and done_o are 0 and the machine is in IDLE. In IDLE, data bits change nothing until a start pulse arrives.
- R2: A start_i pulse in any state zeroes rem_o, quo_o and done_o at that clock edge and enters SHIFT. It takes priority over pad_i and bit_vld_i in the same cycle.
- R3: In SHIFT with bit_vld_i high, one step takes place. The quotient bit q is the old rem_o[N-1]. The new remainder is {old rem_o[N-2:0], bit_i} XOR (gen_i[N-1:0] AND q). quo_o shows q after the edge. gen_i[N] is ignored and treated as 1.
- R4: In SHIFT with bit_vld_i low, and with no start or pad request, rem_o and quo_o keep their values.
- R5: A pad_i in SHIFT enters PAD, and the data bit of that cycle is dropped. PAD then shifts exactly N zero bits, one per clock, and ignores bit_i and bit_vld_i.
- R6: done_o rises in the cycle after the edge that shifts the last pad bit. It stays high, with rem_o frozen, until the next start.
- R7: In generator mode, the final rem_o equals the remainder of the message times x^N, divided modulo-2 by the generator. The worked case is message 10010101 with generator 1011.
- R8: In checker mode, a message followed by its own check value, most significant bit first and without padding, leaves rem_o equal to 0.
- R9: The generator is taken from gen_i during each step. It must be held stable within a run and may differ between runs, and each run's result follows the generator of that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_i | input | N+1 | Generator coefficients; the top bit is assumed to be 1 |
| start_i | input | 1 | Start/clear pulse |
| bit_vld_i | input | 1 | Data bit valid strobe |
| bit_i | input | 1 | Serial dividend bit, most significant first |
| pad_i | input | 1 | Request to append N zero bits |
| rem_o | output | N | Running remainder |
| quo_o | output | 1 | Quotient bit of the latest step |
| done_o | output | 1 | Padding finished; remainder final |

## Verification
The embedded assertions check these rules on every cycle:
- start clears all outputs;
- the state holds while the valid strobe is low;
- the quotient bit follows the old remainder top bit;
- done stays sticky with a frozen remainder;
- IDLE stays inert;
- the pad counter stays in its range.

Only the bench scenarios can show the arithmetic results. These are the remainder of whole messages under several generators, and the worked 10010101/1011 check value. They also include the zero remainder of the checker round trip, and the data being ignored during padding. The bench shows these by comparing against a long-division model on every clock.

// File: rtl/polydiv_pkg.sv
package polydiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PAD   = 2'd2,
        ST_DONE  = 2'd3
    } pd_state_e;
endpackage

// File: rtl/polydiv_step.sv
// One combinational division step: shift in a bit and conditionally subtract.
module polydiv_step #(
    parameter int N = 3
) (
    input  logic [N-1:0] rem_cur,
    input  logic [N-1:0] gen_low,
    input  logic         din,
    output logic [N-1:0] rem_nxt,
    output logic         qbit
);
    logic [N-1:0] shifted;

    assign qbit = rem_cur[N-1];

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign shifted[i] = din;
        end else begin : g_upper
            assign shifted[i] = rem_cur[i-1];
        end
        assign rem_nxt[i] = shifted[i] ^ (gen_low[i] & qbit);
    end
endmodule

// File: rtl/polydiv_padcnt.sv
// Counts the zero bits appended during padding.
module polydiv_padcnt #(
    parameter int N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic last
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LOADV = CW'(N);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOADV;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CW'(1));

    // R5: the pad count never exceeds the generator degree
    assert_pad_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOADV);

    // R5: a load is followed by a full count of N
    assert_pad_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == LOADV);
endmodule

// File: rtl/polydiv_serial.sv
module polydiv_serial #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N:0]   gen_i,
    input  logic         start_i,
    input  logic         bit_vld_i,
    input  logic         bit_i,
    input  logic         pad_i,
    output logic [N-1:0] rem_o,
    output logic         quo_o,
    output logic         done_o
);
    import polydiv_pkg::*;

    pd_state_e    state, state_nxt;
    logic         shift_en;
    logic         din_sel;
    logic         pad_load;
    logic         pad_dec;
    logic         pad_last;
    logic [N-1:0] rem_step;
    logic         q_step;

    polydiv_step #(.N(N)) u_step (
        .rem_cur (rem_o),
        .gen_low (gen_i[N-1:0]),
        .din     (din_sel),
        .rem_nxt (rem_step),
        .qbit    (q_step)
    );

    polydiv_padcnt #(.N(N)) u_padcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pad_load),
        .dec   (pad_dec),
        .last  (pad_last)
    );

    // Next-state and step control
    always_comb begin
        state_nxt = state;
        shift_en  = 1'b0;
        din_sel   = bit_i;
        pad_load  = 1'b0;
        pad_dec   = 1'b0;
        if (start_i) begin
            state_nxt = ST_SHIFT;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nxt = ST_IDLE;
                end
                ST_SHIFT: begin
                    if (pad_i) begin
                        state_nxt = ST_PAD;
                        pad_load  = 1'b1;
                    end else if (bit_vld_i) begin
                        shift_en = 1'b1;
                    end
                end
                ST_PAD: begin
                    shift_en = 1'b1;
                    din_sel  = 1'b0;
                    pad_dec  = 1'b1;
                    if (pad_last) begin
                        state_nxt = ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_nxt = ST_DONE;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_o  <= '0;
            quo_o  <= 1'b0;
            done_o <= 1'b0;
        end else if (start_i) begin
            rem_o  <= '0;
            quo_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            if (shift_en) begin
                rem_o <= rem_step;
                quo_o <= q_step;
            end
            done_o <= (state_nxt == ST_DONE);
        end
    end

    // R2: start clears every output
    assert_start_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (rem_o == '0 && !quo_o && !done_o));

    // R3: quotient bit is the previous remainder top bit
    assert_qbit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !start_i && !pad_i && bit_vld_i)
        |=> quo_o == $past(rem_o[N-1]));

    // R4: no valid bit, no change
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !start_i && !pad_i && !bit_vld_i)
        |=> ($stable(rem_o) && $stable(quo_o)));

    // R6: done is sticky and the remainder frozen until start
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(rem_o)));

    // R6: done only rises out of padding
    assert_done_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state) == ST_PAD);

    // R1: idle ignores data
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_i) |=> (rem_o == '0 && !done_o));
endmodule

// File: tb/polydiv_serial_tb.sv
module polydiv_serial_tb;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N:0]   gen_i = 4'b1011;
    logic         start_i = 1'b0;
    logic         bit_vld_i = 1'b0;
    logic         bit_i = 1'b0;
    logic         pad_i = 1'b0;
    logic [N-1:0] rem_o;
    logic         quo_o;
    logic         done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    polydiv_serial #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .gen_i(gen_i), .start_i(start_i),
        .bit_vld_i(bit_vld_i), .bit_i(bit_i), .pad_i(pad_i),
        .rem_o(rem_o), .quo_o(quo_o), .done_o(done_o)
    );

    // Behavioural model: whole dividend kept as an integer, divided from scratch
    int           m_mode = 0;   // 0 idle, 1 run, 2 pad, 3 done
    int           m_padleft = 0;
    logic [127:0] m_val = '0;
    int           m_len = 0;
    logic [N-1:0] m_rem = '0;
    logic         m_quo = 1'b0;
    logic         m_done = 1'b0;

    function automatic logic [N-1:0] ref_div(input logic [127:0] v_in, input int len,
                                             input logic [N:0] g);
        logic [127:0] v = v_in;
        logic [127:0] gf = '0;
        gf[N:0] = {1'b1, g[N-1:0]};
        for (int i = len - 1; i >= N; i--) begin
            if (v[i]) v = v ^ (gf << (i - N));
        end
        return v[N-1:0];
    endfunction

    task automatic push_bit(input logic b);
        m_quo = m_rem[N-1];
        m_val = {m_val[126:0], b};
        m_len++;
        m_rem = ref_div(m_val, m_len, gen_i);
    endtask

    task automatic model_edge(input logic s, input logic v, input logic b, input logic p);
        if (s) begin
            m_mode = 1; m_val = '0; m_len = 0; m_rem = '0; m_quo = 0; m_done = 0;
        end else if (m_mode == 1) begin
            if (p) begin
                m_mode = 2; m_padleft = N;
            end else if (v) begin
                push_bit(b);
            end
        end else if (m_mode == 2) begin
            push_bit(1'b0);
            m_padleft--;
            if (m_padleft == 0) begin
                m_mode = 3; m_done = 1;
            end
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic v, input logic b, input logic p);
        start_i = s; bit_vld_i = v; bit_i = b; pad_i = p;
        @(posedge clk);
        model_edge(s, v, b, p);
        @(negedge clk);
        check("R3 R4 R5 rem per-cycle", int'(rem_o), int'(m_rem));
        check("R3 quo per-cycle", int'(quo_o), int'(m_quo));
        check("R6 done per-cycle", int'(done_o), int'(m_done));
    endtask

    task automatic feed(input logic [63:0] msg, input int len, input bit gaps);
        for (int i = len - 1; i >= 0; i--) begin
            cyc(0, 1, msg[i], 0);
            if (gaps && (i % 3 == 0)) cyc(0, 0, ~msg[i], 0);
        end
    endtask

    task automatic pad_run();
        cyc(0, 1, 1, 1);                                        // data bit dropped
        for (int i = 0; i < N; i++) cyc(0, 1, 1'b1, 0);         // noise ignored
        cyc(0, 1, 1, 0);
    endtask

    initial begin
        logic [N-1:0] crc_a;
        logic [63:0]  rmsg;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset rem", int'(rem_o), 0);
        check("R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle ignores data
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0);
        check("R1 idle rem", int'(rem_o), 0);

        // R7: worked case 10010101 / 1011 with padding
        gen_i = 4'b1011;
        cyc(1, 0, 0, 0);
        feed(64'b10010101, 8, 1);
        pad_run();
        crc_a = rem_o;
        check("R7 worked crc", int'(crc_a), int'(ref_div(128'b10010101000, 11, 4'b1011)));
        check("R6 done high", int'(done_o), 1);
        cyc(0, 1, 0, 1);
        check("R6 done frozen rem", int'(rem_o), int'(crc_a));

        // R8: checker round trip
        cyc(1, 0, 0, 0);
        check("R2 start clears done", int'(done_o), 0);
        feed(64'b10010101, 8, 0);
        feed({61'b0, crc_a}, N, 0);
        check("R8 zero remainder", int'(rem_o), 0);

        // R2: start mid-run wins over a valid bit
        cyc(0, 1, 1, 0);
        cyc(1, 1, 1, 1);
        check("R2 start priority", int'(rem_o), 0);

        // R9: other generators, random message
        rmsg = {$urandom, $urandom};
        gen_i = 4'b1101;
        cyc(1, 0, 0, 0);
        feed(rmsg, 24, 1);
        pad_run();
        check("R9 gen 1101 crc", int'(rem_o),
              int'(ref_div({101'b0, rmsg[23:0], 3'b000}, 27, 4'b1101)));
        gen_i = 4'b1111;
        cyc(1, 0, 0, 0);
        feed(rmsg, 30, 0);
        pad_run();

        // R3: top generator bit ignored (0011 acts as 1011)
        gen_i = 4'b0011;
        cyc(1, 0, 0, 0);
        feed(64'b10010101, 8, 0);
        pad_run();
        check("R3 top bit ignored", int'(rem_o), int'(crc_a));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule